// File: doc/BRIEF.md
# Head-of-Line Blocking Timeout Timer

This block times how long one endpoint's head packet has been stuck. It counts only while head-of-line blocking detection is enabled for the endpoint and the head is reported as blocked. Time is measured in ticks, and each tick is 128 core clock cycles. When the programmed number of ticks has elapsed, the block raises a one-cycle timeout pulse, which the packet logic around it uses to drop the stuck packet.

The period comes from a 32-bit configuration register. A mode input selects how that register is read. In wide mode the register value is the tick count itself. In compact mode a small base is shifted left by a scale to reach long periods with few bits. A period of zero means the timeout fires at once. The count starts over whenever the head is no longer blocked, the enable drops, or the register is written.

Top module: `holb_timer`

## Requirements
- R1: After a synchronous reset `expire` is 0 and `cfg_rdata` is 0.
- R2: `cfg_rdata` reflects the register one cycle after a write. In wide mode (`fmt_compact`=0) it returns all 32 bits. In compact mode it returns only bits [4:0] (base) and [12:8] (scale), and every other bit reads 0.
- R3: In wide mode a nonzero value T sets the period to T ticks. `expire` rises in the cycle after the 128*T-th consecutive rising edge at which `holb_en` and `head_blocked` are both 1 and no write occurs.
- R4: In compact mode the period is base << scale ticks, with base = bits [4:0] and scale = bits [12:8]. All other register bits have no effect on timing.
- R5: A period of zero ticks makes `expire` rise in the cycle after the first rising edge at which the head is blocked with the enable set.
- R6: `expire` stays high for exactly one cycle. No further pulse occurs while the blocked condition stays continuously true.
- R7: Deasserting `head_blocked` for one edge discards all elapsed time. The next expiry needs a full period from the re-arm.
- R8: Clearing `holb_en` for one edge discards all elapsed time in the same way.
- R9: A register write while counting restarts the count. The new period is measured from the edge after the write edge.
- R10: `expire` is high only in a cycle whose preceding edge saw both `holb_en` and `head_blocked` high with no write. The tick target is held in 64 bits, so no base/scale combination can wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| fmt_compact | input | 1 | 1 = base/scale format, 0 = wide tick count |
| holb_en | input | 1 | Head-of-line blocking detection enable |
| head_blocked | input | 1 | Head packet of the endpoint is stalled |
| expire | output | 1 | Single-cycle timeout pulse |
| cfg_rdata | output | 32 | Registered configuration readback |

## Verification
The assertions assume that `fmt_compact` is a static configuration choice. It is changed only while the timer is idle, so the period never changes under a running count except through a write. The stimulus changes the mode only with `head_blocked` low. It drives every input half a cycle away from the sampling edge, so each edge sees one stable combination of enable, blocked and write. Wide-mode periods stay at a few ticks, so the reference model can follow every edge within the cycle budget.

// File: rtl/holb_pkg.sv
package holb_pkg;
  localparam int REG_W     = 32;
  localparam int TGT_W     = 64;
  localparam int PRE_DIV   = 128;
  localparam int BASE_LSB  = 0;
  localparam int BASE_W    = 5;
  localparam int SCALE_LSB = 8;
  localparam int SCALE_W   = 5;

  typedef enum logic {FMT_WIDE = 1'b0, FMT_COMPACT = 1'b1} fmt_e;

  function automatic logic [REG_W-1:0] compact_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < BASE_W; i++)  m[BASE_LSB + i]  = 1'b1;
    for (int i = 0; i < SCALE_W; i++) m[SCALE_LSB + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/holb_cfg_reg.sv
module holb_cfg_reg
  import holb_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int TW = TGT_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  input  logic          fmt,
  output logic [RW-1:0] rdata,
  output logic [TW-1:0] target
);
  localparam logic [RW-1:0] CMASK = RW'(compact_mask());

  logic [RW-1:0]      store_q;
  logic [BASE_W-1:0]  base_f;
  logic [SCALE_W-1:0] scale_f;
  logic [TW-1:0]      tgt_wide;
  logic [TW-1:0]      tgt_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      rdata   <= '0;
    end else begin
      rdata <= (fmt_e'(fmt) == FMT_COMPACT) ? (store_q & CMASK) : store_q;
      if (we) store_q <= wdata;
    end
  end

  assign base_f   = store_q[BASE_LSB +: BASE_W];
  assign scale_f  = store_q[SCALE_LSB +: SCALE_W];
  assign tgt_wide = TW'(store_q);
  assign tgt_cmp  = TW'(base_f) << scale_f;

  always_comb begin
    target = (fmt_e'(fmt) == FMT_COMPACT) ? tgt_cmp : tgt_wide;
  end
endmodule

// File: rtl/holb_prescaler.sv
module holb_prescaler #(
  parameter int DIV = 128
)(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc_q <= '0;
    end else if (run) begin
      pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
    end
  end

  assign tick = run && (pc_q == LAST);
endmodule

// File: rtl/holb_tick_counter.sv
module holb_tick_counter #(
  parameter int TW = 64
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] target,
  output logic          done,
  output logic          expire
);
  logic [TW-1:0] tc_q;
  logic          zero_tgt;
  logic          reach;

  assign zero_tgt = (target == '0);
  assign reach    = tick && ((tc_q + 1'b1) == target);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tc_q   <= '0;
      done   <= 1'b0;
      expire <= 1'b0;
    end else if (run && (zero_tgt || reach)) begin
      done   <= 1'b1;
      expire <= 1'b1;
    end else begin
      expire <= 1'b0;
      if (run && tick) tc_q <= tc_q + 1'b1;
    end
  end
endmodule

// File: rtl/holb_timer.sv
module holb_timer
  import holb_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int TW  = TGT_W,
  parameter int DIV = PRE_DIV
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          fmt_compact,
  input  logic          holb_en,
  input  logic          head_blocked,
  output logic          expire,
  output logic [RW-1:0] cfg_rdata
);
  logic [TW-1:0] target;
  logic          armed;
  logic          clr;
  logic          run;
  logic          tick;
  logic          done;

  assign armed = holb_en && head_blocked;
  assign clr   = !armed || cfg_we;
  assign run   = armed && !cfg_we && !done;

  holb_cfg_reg #(.RW(RW), .TW(TW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .fmt(fmt_compact), .rdata(cfg_rdata), .target(target)
  );

  holb_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .tick(tick)
  );

  holb_tick_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .tick(tick),
    .target(target), .done(done), .expire(expire)
  );
endmodule

// File: rtl/holb_timer_chk.sv
module holb_timer_chk #(
  parameter int RW = 32
)(
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          fmt_compact,
  input logic          holb_en,
  input logic          head_blocked,
  input logic          expire,
  input logic [RW-1:0] cfg_rdata
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  a_r7_unblock_clears: assert property (@(posedge clk) disable iff (rst)
    !head_blocked |=> !expire);

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !holb_en |=> !expire);

  a_r9_write_restarts: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !expire);

  a_r2_compact_zero_bits: assert property (@(posedge clk) disable iff (rst)
    fmt_compact |=> (cfg_rdata[RW-1:13] == '0) && (cfg_rdata[7:5] == '0));

  a_r10_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (!holb_en || !head_blocked || cfg_we) |=> !expire);
endmodule

bind holb_timer holb_timer_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .fmt_compact(fmt_compact),
  .holb_en(holb_en), .head_blocked(head_blocked), .expire(expire),
  .cfg_rdata(cfg_rdata)
);

// File: tb/holb_timer_test.sv
`timescale 1ns/1ps
module holb_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        fmt_compact = 1'b0;
  logic        holb_en = 1'b0;
  logic        head_blocked = 1'b0;
  logic        expire;
  logic [31:0] cfg_rdata;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    pulses = 0;

  // behavioural reference state
  logic [31:0] m_reg = '0;
  logic [31:0] m_rd  = '0;
  logic        m_exp = 1'b0;
  logic        m_done = 1'b0;
  longint      m_cycles = 0;
  bit          model_on = 1'b0;

  always #5 clk = ~clk;

  holb_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fmt_compact(fmt_compact), .holb_en(holb_en),
    .head_blocked(head_blocked), .expire(expire), .cfg_rdata(cfg_rdata)
  );

  function automatic longint period_ticks(logic [31:0] r, logic cmp);
    longint b, s;
    if (!cmp) return longint'(r);
    b = longint'(r & 32'h1F);
    s = longint'((r >> 8) & 32'h1F);
    return b << s;
  endfunction

  always @(posedge clk) begin
    longint t;
    if (rst) begin
      m_reg = '0; m_rd = '0; m_exp = 1'b0; m_done = 1'b0; m_cycles = 0;
    end else begin
      t = period_ticks(m_reg, fmt_compact);
      m_rd = fmt_compact ? (m_reg & 32'h0000_1F1F) : m_reg;
      if (!(holb_en && head_blocked) || cfg_we) begin
        m_cycles = 0; m_done = 1'b0; m_exp = 1'b0;
      end else if (m_done) begin
        m_exp = 1'b0;
      end else begin
        m_cycles++;
        if (t == 0 || m_cycles == 128 * t) begin
          m_exp = 1'b1; m_done = 1'b1;
        end else m_exp = 1'b0;
      end
      if (cfg_we) m_reg = cfg_wdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check(cur_req, {31'b0, expire}, {31'b0, m_exp});
      check("R2", cfg_rdata, m_rd);
      if (expire === 1'b1) pulses++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic expect_pulses(string req, int n);
    check(req, pulses, n);
    pulses = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R1", {31'b0, expire}, 32'd0);
    check("R1", cfg_rdata, 32'd0);
    model_on = 1'b1;

    // R3: wide mode, one tick
    cur_req = "R3";
    holb_en = 1'b1;
    write_cfg(32'd1);
    step(2);
    check("R2", cfg_rdata, 32'd1);
    head_blocked = 1'b1;
    step(140);
    expect_pulses("R3", 1);
    // R6: holding blocked gives no second pulse
    cur_req = "R6";
    step(300);
    expect_pulses("R6", 0);
    head_blocked = 1'b0;
    step(1);

    // R3: three ticks
    cur_req = "R3";
    write_cfg(32'd3);
    step(1);
    head_blocked = 1'b1;
    step(383);
    expect_pulses("R3", 0);
    step(3);
    expect_pulses("R3", 1);

    // R7: unblock mid-count discards progress
    cur_req = "R7";
    head_blocked = 1'b0; step(1);
    head_blocked = 1'b1; step(200);
    head_blocked = 1'b0; step(1);
    head_blocked = 1'b1; step(380);
    expect_pulses("R7", 0);
    step(10);
    expect_pulses("R7", 1);

    // R8: enable drop mid-count discards progress
    cur_req = "R8";
    holb_en = 1'b0; step(1);
    holb_en = 1'b1; step(300);
    holb_en = 1'b0; step(1);
    holb_en = 1'b1; step(380);
    expect_pulses("R8", 0);
    step(10);
    expect_pulses("R8", 1);

    // R4: compact, base 2 scale 2 => 8 ticks, noise in other bits
    cur_req = "R4";
    head_blocked = 1'b0;
    fmt_compact = 1'b1;
    write_cfg(32'hABCD_02E2);
    step(2);
    check("R2", cfg_rdata, 32'h0000_0202);
    head_blocked = 1'b1;
    step(1020);
    expect_pulses("R4", 0);
    step(10);
    expect_pulses("R4", 1);

    // R9: rewrite while counting, new period 1 tick
    cur_req = "R9";
    head_blocked = 1'b0; step(1);
    head_blocked = 1'b1; step(500);
    write_cfg(32'h0000_0001);
    step(126);
    expect_pulses("R9", 0);
    step(5);
    expect_pulses("R9", 1);

    // R5: compact zero base with nonzero scale => immediate
    cur_req = "R5";
    head_blocked = 1'b0;
    write_cfg(32'h0000_0300);
    step(1);
    head_blocked = 1'b1;
    step(1);
    check("R5", {31'b0, expire}, 32'd1);
    step(20);
    expect_pulses("R5", 1);

    // R5: wide mode zero
    head_blocked = 1'b0;
    fmt_compact = 1'b0;
    write_cfg(32'd0);
    step(2);
    check("R2", cfg_rdata, 32'd0);
    head_blocked = 1'b1;
    step(1);
    check("R5", {31'b0, expire}, 32'd1);
    step(5);
    expect_pulses("R5", 1);

    // R10: blocked without enable never expires
    cur_req = "R10";
    holb_en = 1'b0;
    step(20);
    expect_pulses("R10", 0);

    // R2: wide readback of full word
    head_blocked = 1'b0;
    write_cfg(32'hDEAD_BEEF);
    step(2);
    check("R2", cfg_rdata, 32'hDEAD_BEEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule